// File: doc/BRIEF.md
# Serial Converter Digital Front End

This block models the digital half of a four-channel sampling converter. A host starts conversions and reads results with two active-low strobes, `csN` (select) and `rcN` (read/convert). A conversion lasts a fixed number of system clock cycles. During that time `busyN` is low. When the conversion ends, the block captures the word on `resultIn` together with the channel address held in the address latch. The analog front end is not modelled: `resultIn` stands in for the quantiser output.

Results leave the block on `dataOut`, most significant bit first, in one of two clocking modes. With `extMode` low, the block makes a burst of sixteen data-clock periods on `dataClkOut` each time a conversion starts. That burst carries the result of the previous conversion. With `extMode` high, the host supplies its own data clock on `extClkIn`, which the block synchronises into the system domain. A read started with the strobes then shifts out the word, optionally preceded by a one-period frame pulse on `syncOut`. A power-down input blocks new conversions and leaves the stored result untouched.

Top module: `adc_serial_if`

## Requirements
- R1: After reset, `busyN`=1, `dataOut`=0, `dataClkOut`=0, `syncOut`=0 and `chanOut`=0.
- R2: A conversion starts on a falling `rcN` while `csN` is low, or on a falling `csN` while `rcN` is low. `busyN` goes low at the next clock edge and stays low for exactly CONV_CYCLES cycles.
- R3: When `busyN` returns high, the stored result equals `resultIn` and `chanOut` equals the latched channel code. Codes 00, 01, 10 and 11 select channels 1, 2, 3 and 4.
- R4: The channel latch follows `addrIn` on every clock edge at which `wrA` and `wrB` are both low. It holds while either of them is high.
- R5: While `pwrDown` is high, conversion starts are ignored (`busyN` stays high and no burst is produced), and the stored result is kept for a later read.
- R6: Conversion starts are ignored while a conversion is in progress or an internal-clock burst is running.
- R7: With `extMode` low, a conversion start produces 16 periods of 2*DCLK_HALF cycles on `dataClkOut`. In each period the clock is low for the first half and high for the second. `dataOut` holds one bit of the previous result for the whole period, MSB first. Afterwards `dataClkOut` and `dataOut` are 0.
- R8: With `extMode` high, a read starts on a falling `csN` while `rcN` is high, or on a rising `rcN` while `csN` is low. `dataClkOut` stays 0.
- R9: Number the rising edges of `extClkIn` after a read start from 1. After edge 1, `syncOut` is high if armed. After edge 2, `syncOut` is low and `dataOut` carries bit 15. Edges 3 to 17 each move to the next lower bit. After edge 18, `dataOut` returns to 0.
- R10: The frame pulse is armed by a rising `extClkIn` edge, outside a read, while `csN` is high or while `csN` and `rcN` are both low. Without arming, `syncOut` stays low and the data timing is unchanged.
- R11: An external-clock read started during a conversion returns the result of the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select strobe |
| rcN | input | 1 | Read/convert strobe (low = convert) |
| extMode | input | 1 | 1 = host-supplied data clock, 0 = internal burst |
| extClkIn | input | 1 | Host data clock, asynchronous to `clk` |
| pwrDown | input | 1 | Blocks conversions while high |
| wrA | input | 1 | Address latch write gate, first input |
| wrB | input | 1 | Address latch write gate, second input |
| addrIn | input | 2 | Channel address |
| resultIn | input | WORD_W | Conversion word captured at end of conversion |
| busyN | output | 1 | Low while a conversion runs |
| dataClkOut | output | 1 | Internal burst data clock |
| dataOut | output | 1 | Serial result, MSB first |
| syncOut | output | 1 | Frame pulse in external-clock mode |
| chanOut | output | 2 | Channel code of the last finished conversion |

## Verification
The bench sweeps all four channel codes and alternates the two conversion-start orderings. It checks every system cycle of each burst, so an error in phase or bit order shows at once as a wrong `dataOut` or `dataClkOut` sample, and a burst that carried the new word instead of the old one fails bit by bit. Extra strobe edges are injected during a conversion and during a burst. A design that restarted on them would hold `busyN` low too long, or leave it high after the conversion should have begun. External reads are run armed and unarmed, during a conversion and after one, and each strobe ordering is used. A misplaced frame pulse, a one-edge slip in the shift schedule, or a read that returns the fresh result too early therefore each fail at the exact clock edge where they go wrong.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

  // Strobes the control path issues to the datapath, one cycle each.
  typedef struct packed {
    logic convDone;  // capture resultIn and channel code
    logic xferLoad;  // copy the stored result into the transmit register
    logic shiftBit;  // advance the transmit register by one bit
  } strobe_t;

  localparam int CHAN_W = 2;

endpackage

// File: rtl/adcif_edge.sv
module adcif_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], din};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);

endmodule

// File: rtl/adcif_ctrl.sv
module adcif_ctrl
  import adcif_pkg::*;
#(
  parameter int CONV_CYCLES = 24,
  parameter int DCLK_HALF   = 2,
  parameter int WORD_W      = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    csN,
  input  logic    rcN,
  input  logic    extMode,
  input  logic    pwrDown,
  input  logic    extRise,
  output logic    busyN,
  output logic    dataClkOut,
  output logic    syncOut,
  output logic    dataEn,
  output strobe_t strobe
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int PH_W  = $clog2(2 * DCLK_HALF);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int PC_W  = $clog2(WORD_W + 3);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(2 * DCLK_HALF - 1);
  localparam logic [PH_W-1:0]  PH_HIGH  = PH_W'(DCLK_HALF);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [PC_W-1:0]  P_SYNC   = PC_W'(1);
  localparam logic [PC_W-1:0]  P_MSB    = PC_W'(2);
  localparam logic [PC_W-1:0]  P_LSB    = PC_W'(WORD_W + 1);
  localparam logic [PC_W-1:0]  P_END    = PC_W'(WORD_W + 2);

  // strobe edge detection
  logic csPrev, rcPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev <= 1'b1;
      rcPrev <= 1'b1;
    end else begin
      csPrev <= csN;
      rcPrev <= rcN;
    end
  end

  logic csFall, rcFall, rcRise, convReq, readReq, convGo, readGo;
  logic busy, burstOn, extOn;

  assign csFall  = csPrev & ~csN;
  assign rcFall  = rcPrev & ~rcN;
  assign rcRise  = ~rcPrev & rcN;
  assign convReq = (rcFall & ~csN) | (csFall & ~rcN);
  assign readReq = (csFall & rcN) | (rcRise & ~csN);
  assign convGo  = convReq & ~pwrDown & ~busy & ~burstOn;
  assign readGo  = readReq & extMode & ~extOn;

  // conversion timer
  logic [CNT_W-1:0] convCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      convCnt <= '0;
    end else if (convGo) begin
      busy    <= 1'b1;
      convCnt <= CNT_W'(CONV_CYCLES - 1);
    end else if (busy) begin
      if (convCnt == '0) busy <= 1'b0;
      else               convCnt <= convCnt - 1'b1;
    end
  end

  assign busyN = ~busy;

  // internal-clock burst
  logic [PH_W-1:0]  phase;
  logic [BIT_W-1:0] bitIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstOn <= 1'b0;
      phase   <= '0;
      bitIdx  <= '0;
    end else if (convGo && !extMode) begin
      burstOn <= 1'b1;
      phase   <= '0;
      bitIdx  <= '0;
    end else if (burstOn) begin
      if (phase == PH_LAST) begin
        phase <= '0;
        if (bitIdx == BIT_LAST) burstOn <= 1'b0;
        else                    bitIdx  <= bitIdx + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end

  assign dataClkOut = burstOn && (phase >= PH_HIGH);

  // external-clock read sequencer
  logic            syncEn, armed, extData, syncReg;
  logic [PC_W-1:0] pulseCnt, nextPulse;
  assign nextPulse = pulseCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extOn    <= 1'b0;
      syncEn   <= 1'b0;
      armed    <= 1'b0;
      extData  <= 1'b0;
      syncReg  <= 1'b0;
      pulseCnt <= '0;
    end else if (readGo) begin
      extOn    <= 1'b1;
      syncEn   <= armed;
      armed    <= 1'b0;
      extData  <= 1'b0;
      syncReg  <= 1'b0;
      pulseCnt <= '0;
    end else if (extOn && extRise) begin
      pulseCnt <= nextPulse;
      if (nextPulse == P_SYNC) syncReg <= syncEn;
      if (nextPulse == P_MSB) begin
        syncReg <= 1'b0;
        extData <= 1'b1;
      end
      if (nextPulse == P_END) begin
        extData <= 1'b0;
        extOn   <= 1'b0;
      end
    end else if (!extOn && extRise && extMode && (csN || !rcN)) begin
      armed <= 1'b1;
    end
  end

  logic shiftInt, shiftExt;
  assign shiftInt = burstOn && (phase == PH_LAST);
  assign shiftExt = extOn && extRise && (nextPulse > P_MSB) && (nextPulse <= P_LSB);

  assign strobe.convDone = busy && (convCnt == '0);
  assign strobe.xferLoad = (convGo && !extMode) || readGo;
  assign strobe.shiftBit = shiftInt || shiftExt;
  assign dataEn  = burstOn | extData;
  assign syncOut = syncReg;

  // checker counter: cycles spent busy
  logic [CNT_W-1:0] busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else           busyLen <= '0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyN) |-> (busyLen == CNT_W'(CONV_CYCLES)));

  // R5
  pwr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> !$past(pwrDown));

  // R8
  int_clk_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    extMode |-> !dataClkOut);

  // R9
  sync_data_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncOut |-> !dataEn);

endmodule

// File: rtl/adcif_dpath.sv
module adcif_dpath
  import adcif_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              dataEn,
  input  logic              wrA,
  input  logic              wrB,
  input  logic [CHAN_W-1:0] addrIn,
  input  logic [WORD_W-1:0] resultIn,
  output logic              dataOut,
  output logic [CHAN_W-1:0] chanOut
);

  logic [CHAN_W-1:0] chanLatch, convChan;
  logic [WORD_W-1:0] resultReg, txReg;

  // address latch, open while both write gates are low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             chanLatch <= '0;
    else if (!(wrA | wrB)) chanLatch <= addrIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg <= '0;
      convChan  <= '0;
    end else if (strobe.convDone) begin
      resultReg <= resultIn;
      convChan  <= chanLatch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txReg <= '0;
    else if (strobe.xferLoad) txReg <= resultReg;
    else if (strobe.shiftBit) txReg <= {txReg[WORD_W-2:0], 1'b0};
  end

  assign dataOut = dataEn & txReg[WORD_W-1];
  assign chanOut = convChan;

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrA || wrB) |=> $stable(chanLatch));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.convDone |=> $stable(resultReg));

  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.convDone |=> $stable(chanOut));

endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
  import adcif_pkg::*;
#(
  parameter int CONV_CYCLES = 24,
  parameter int DCLK_HALF   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rcN,
  input  logic              extMode,
  input  logic              extClkIn,
  input  logic              pwrDown,
  input  logic              wrA,
  input  logic              wrB,
  input  logic [1:0]        addrIn,
  input  logic [WORD_W-1:0] resultIn,
  output logic              busyN,
  output logic              dataClkOut,
  output logic              dataOut,
  output logic              syncOut,
  output logic [1:0]        chanOut
);

  strobe_t strobe;
  logic    extRise, dataEn;

  adcif_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rstN(rstN), .din(extClkIn), .rise(extRise)
  );

  adcif_ctrl #(
    .CONV_CYCLES(CONV_CYCLES), .DCLK_HALF(DCLK_HALF), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN), .extMode(extMode),
    .pwrDown(pwrDown), .extRise(extRise), .busyN(busyN),
    .dataClkOut(dataClkOut), .syncOut(syncOut), .dataEn(dataEn),
    .strobe(strobe)
  );

  adcif_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataEn(dataEn),
    .wrA(wrA), .wrB(wrB), .addrIn(addrIn), .resultIn(resultIn),
    .dataOut(dataOut), .chanOut(chanOut)
  );

endmodule

// File: tb/adc_serial_if_bench.sv
module adc_serial_if_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 12;
  localparam int HALF       = 2;
  localparam int W          = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rcN = 1'b1, extMode = 1'b0, extClkIn = 1'b0, pwrDown = 1'b0;
  logic wrA = 1'b0, wrB = 1'b0;
  logic [1:0]   addrIn = '0;
  logic [W-1:0] resultIn = '0;
  logic busyN, dataClkOut, dataOut, syncOut;
  logic [1:0] chanOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_if #(.CONV_CYCLES(CONV), .DCLK_HALF(HALF), .SYNC_STAGES(2), .WORD_W(W)) u_adc_serial_if (
    .clk(clk), .rstN(rstN), .csN(csN), .rcN(rcN), .extMode(extMode),
    .extClkIn(extClkIn), .pwrDown(pwrDown), .wrA(wrA), .wrB(wrB),
    .addrIn(addrIn), .resultIn(resultIn), .busyN(busyN),
    .dataClkOut(dataClkOut), .dataOut(dataOut), .syncOut(syncOut),
    .chanOut(chanOut)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] pat(input int ch);
    return W'(16'hA53C + ch * 16'h1357);
  endfunction

  task automatic extPulse();
    extClkIn = 1'b1;
    repeat (4) tick();
    extClkIn = 1'b0;
    repeat (4) tick();
  endtask

  // read already started; walk edges 1..18
  task automatic readPulses(input logic [W-1:0] exp, input bit expSync);
    for (int p = 1; p <= W + 2; p++) begin
      logic expD;
      extPulse();
      expD = (p >= 2 && p <= W + 1) ? exp[W + 1 - p] : 1'b0;
      check(syncOut == ((p == 1) ? expSync : 1'b0), "R9/R10 syncOut", syncOut, (p == 1) ? expSync : 1'b0);
      check(dataOut == expD, "R9 dataOut", dataOut, expD);
      check(dataClkOut == 1'b0, "R8 dataClkOut", dataClkOut, 0);
    end
    csN = 1'b1;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // R1
    check(busyN == 1'b1, "R1 busyN", busyN, 1);
    check(dataOut == 1'b0, "R1 dataOut", dataOut, 0);
    check(dataClkOut == 1'b0, "R1 dataClkOut", dataClkOut, 0);
    check(syncOut == 1'b0, "R1 syncOut", syncOut, 0);
    check(chanOut == 2'd0, "R1 chanOut", chanOut, 0);

    // internal-clock sweep over all channel codes
    prev = '0;
    for (int ch = 0; ch < 4; ch++) begin
      wrA = 1'b0; wrB = 1'b0; addrIn = 2'(ch);
      tick(); tick();
      wrB = 1'b1; addrIn = ~2'(ch);          // R4: latch must hold
      resultIn = pat(ch);
      if (ch % 2 == 0) begin
        rcN = 1'b0; tick(); csN = 1'b0;      // R2: select falls while rcN low
      end else begin
        csN = 1'b0; tick(); rcN = 1'b0;      // R2: rcN falls while select low
      end
      tick();
      for (int c = 0; c < 32 * HALF; c++) begin
        logic expB, expC, expD;
        expB = (c < CONV) ? 1'b0 : 1'b1;
        expC = ((c % (2 * HALF)) >= HALF);
        expD = prev[W - 1 - c / (2 * HALF)];
        check(busyN == expB, "R2/R6 busyN", busyN, expB);
        check(dataClkOut == expC, "R7 dataClkOut", dataClkOut, expC);
        check(dataOut == expD, "R7 dataOut", dataOut, expD);
        if (ch == 2) begin                   // R6: extra starts ignored
          if (c == 2 || c == CONV + 2) csN = 1'b1;
          if (c == 3 || c == CONV + 3) csN = 1'b0;
        end
        tick();
      end
      check(dataClkOut == 1'b0, "R7 clock idle after burst", dataClkOut, 0);
      check(dataOut == 1'b0, "R7 data idle after burst", dataOut, 0);
      check(chanOut == 2'(ch), "R3/R4 chanOut", chanOut, ch);
      csN = 1'b1; tick();
      rcN = 1'b1; tick();
      wrB = 1'b0;
      prev = pat(ch);
    end

    // R5: power-down blocks conversion
    wrB = 1'b1;
    pwrDown = 1'b1; resultIn = 16'h1234;
    rcN = 1'b0; tick(); csN = 1'b0; tick();
    for (int c = 0; c < 2 * CONV; c++) begin
      check(busyN == 1'b1, "R5 busyN held", busyN, 1);
      check(dataClkOut == 1'b0, "R5 no burst", dataClkOut, 0);
      tick();
    end
    csN = 1'b1; tick(); rcN = 1'b1; tick();
    pwrDown = 1'b0;

    // external-clock mode
    extMode = 1'b1;
    tick();
    extPulse();                              // R10: arms with select high
    csN = 1'b0; tick(); tick();              // R8: read via select fall
    readPulses(pat(3), 1'b1);                // R5: old result kept

    csN = 1'b0; tick(); tick();              // R10: no arming pulse
    readPulses(pat(3), 1'b0);

    // R11: read while converting returns previous word
    wrB = 1'b0; addrIn = 2'd1; tick(); tick(); wrB = 1'b1;
    resultIn = 16'h6C19;
    rcN = 1'b0; tick(); csN = 1'b0; tick();
    csN = 1'b1; tick(); rcN = 1'b1; tick();
    csN = 1'b0; tick(); tick();
    check(busyN == 1'b0, "R11 still converting", busyN, 0);
    readPulses(pat(3), 1'b0);
    check(chanOut == 2'd1, "R3 chanOut ext", chanOut, 1);

    // R8/R10: arm with both low, read via rcN rise
    wrB = 1'b0; addrIn = 2'd3; tick(); tick(); wrB = 1'b1;
    resultIn = 16'h9E37;
    rcN = 1'b0; tick(); csN = 1'b0; tick();
    extPulse();
    while (busyN == 1'b0) tick();
    check(chanOut == 2'd3, "R3 chanOut code 11", chanOut, 3);
    rcN = 1'b1; tick(); tick();
    readPulses(16'h9E37, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule